// File: doc/BRIEF.md
# DRAM Bank Command Timing Tracker

This block follows the state of a single DRAM bank and decides, in the same cycle, whether the command presented to it may go out. A scheduler presents one request per cycle. The request carries a command code, a row address and an auto-precharge flag. The block answers with a grant. It also reports whether a row is open, which row that is, and whether the requested row matches it.

Every timing limit is a parameter counted in clock cycles:

- activate to column command
- activate to precharge
- precharge to activate
- activate to activate
- refresh busy time
- CAS latency
- burst length

When a read or write carries the auto-precharge flag, the bank closes itself once the burst has ended. In close-page builds this happens after every column command. In open-page builds the row stays open until the scheduler sends an explicit precharge.

Top module: `dbt_bank_tracker`

## Requirements
- R1: After reset the bank is idle: row_open is 0, open_row is 0, and no grant is given.
- R2: An activate is granted only on an idle bank. From the next cycle row_open is 1 and open_row holds the requested row.
- R3: row_hit is 1 exactly when a row is open and req_row equals it. A read or write to an idle bank, or to a row other than the open one, is refused.
- R4: A read or write to the open row is refused until TRCD cycles after the activate grant. The first such cycle is granted.
- R5: A precharge is refused on an idle bank and until TRAS cycles after the activate. Once granted, it closes the row from the next cycle.
- R6: An activate is refused until TRP cycles after the cycle the row closed, and until TRAS+TRP cycles after the previous activate.
- R7: A read or write granted with req_ap=1 closes the row on its own. This happens at the later of two cycles: the burst end, or TRAS after the activate. The burst end is the grant plus CL+BL/2 for a read, or the grant plus BL/2 for a write. Until the row closes, reads, writes and precharges are refused.
- R8: With CLOSE_PAGE=1, every granted read or write behaves as if req_ap were 1.
- R9: A refresh is granted only on an idle bank once the TRP wait is over. No command is granted for TRFC cycles after the refresh grant.
- R10: With CLOSE_PAGE=0 and req_ap=0, the row stays open, with open_row unchanged, after reads and writes.
- R11: The command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5. NOP and the codes 6 and 7 are never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_cmd | input | 3 | Requested command code |
| req_row | input | ROW_W | Row address of the request |
| req_ap | input | 1 | Auto-precharge flag for reads and writes |
| gnt | output | 1 | Request may issue this cycle (combinational) |
| row_open | output | 1 | A row is open in the bank |
| open_row | output | ROW_W | Open row, 0 when idle |
| row_hit | output | 1 | req_row matches the open row |

## Verification
The grant and row_hit outputs are combinational and depend on the request in the same cycle. The bench therefore drives each request on the falling edge and samples these outputs 1 ns later, before the rising edge that would act on the request. row_open and open_row change on the rising edge after a granted command, or after the implicit close, so each sample reflects everything accepted up to the previous edge. The bench model keeps an absolute cycle number for each event: the last activate, the close, the refresh and the burst end. It derives every expected window by subtraction, and directed steps probe each command type one cycle before its window opens and then on the opening cycle.

// File: rtl/dbt_pkg.sv
`timescale 1ns/1ps
package dbt_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } dbt_cmd_e;

  // cycles from a column grant to the end of its burst
  function automatic int dbt_burst_delay(input bit is_rd, input int cl, input int bl);
    return is_rd ? (cl + bl / 2) : (bl / 2);
  endfunction

  function automatic int dbt_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/dbt_down_ctr.sv
`timescale 1ns/1ps
module dbt_down_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6
endmodule

// File: rtl/dbt_row_state.sv
`timescale 1ns/1ps
module dbt_row_state #(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic [ROW_W-1:0] set_row,
  input  logic             close,
  input  logic [ROW_W-1:0] req_row,
  output logic             row_open,
  output logic [ROW_W-1:0] open_row,
  output logic             hit
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      row_q    <= '0;
    end else if (open_set) begin
      row_open <= 1'b1;
      row_q    <= set_row;
    end else if (close) begin
      row_open <= 1'b0;
    end
  end

  assign open_row = row_open ? row_q : '0;
  assign hit      = row_open && (req_row == row_q);

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (row_open && !close && !open_set) |=> (row_open && $stable(open_row))); // R10
  AST_CLOSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (!row_open && open_row == '0)); // R5
endmodule

// File: rtl/dbt_bank_tracker.sv
`timescale 1ns/1ps
module dbt_bank_tracker
  import dbt_pkg::*;
#(
  parameter int ROW_W      = 14,
  parameter int TRCD       = 3,
  parameter int TRAS       = 8,
  parameter int TRP        = 3,
  parameter int TRFC       = 12,
  parameter int CL         = 3,
  parameter int BL         = 8,
  parameter bit CLOSE_PAGE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       req_cmd,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_ap,
  output logic             gnt,
  output logic             row_open,
  output logic [ROW_W-1:0] open_row,
  output logic             row_hit
);
  localparam int TRC    = TRAS + TRP;
  localparam int RD_DLY = dbt_burst_delay(1'b1, CL, BL);
  localparam int WR_DLY = dbt_burst_delay(1'b0, CL, BL);
  localparam int TMAX   = dbt_max(dbt_max(TRC, TRFC), RD_DLY);
  localparam int CW     = $clog2(TMAX + 1);

  logic is_act, is_rd, is_wr, is_pre, is_ref, is_col;
  logic rcd_done, ras_done, rc_done, rp_done, rfc_done, ap_done;
  logic act_ok, col_ok, pre_ok, ref_ok;
  logic ap_pend, ap_req, ap_fire, close_evt;
  logic act_go, col_go, pre_go, ref_go;
  logic [CW-1:0] ap_load;

  assign is_act = (req_cmd == CMD_ACT);
  assign is_rd  = (req_cmd == CMD_RD);
  assign is_wr  = (req_cmd == CMD_WR);
  assign is_pre = (req_cmd == CMD_PRE);
  assign is_ref = (req_cmd == CMD_REF);
  assign is_col = is_rd || is_wr;

  // legality of each command class this cycle
  assign act_ok = !row_open && rp_done && rc_done && rfc_done;
  assign col_ok = row_open && row_hit && rcd_done && !ap_pend;
  assign pre_ok = row_open && ras_done && !ap_pend;
  assign ref_ok = !row_open && rp_done && rfc_done;

  always_comb begin
    unique case (req_cmd)
      CMD_ACT:        gnt = act_ok;
      CMD_RD, CMD_WR: gnt = col_ok;
      CMD_PRE:        gnt = pre_ok;
      CMD_REF:        gnt = ref_ok;
      default:        gnt = 1'b0;
    endcase
  end

  assign act_go = gnt && is_act;
  assign col_go = gnt && is_col;
  assign pre_go = gnt && is_pre;
  assign ref_go = gnt && is_ref;

  // page policy: which column grants arm the implicit precharge
  generate
    if (CLOSE_PAGE) begin : g_close_page
      assign ap_req = col_go;
    end else begin : g_open_page
      assign ap_req = col_go && req_ap;
    end
  endgenerate

  // implicit precharge waits for both burst end and the TRAS window
  assign ap_fire   = ap_pend && ap_done && ras_done;
  assign close_evt = pre_go || ap_fire;
  assign ap_load   = is_rd ? CW'(RD_DLY - 1) : CW'(WR_DLY - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       ap_pend <= 1'b0;
    else if (ap_req)  ap_pend <= 1'b1;
    else if (ap_fire) ap_pend <= 1'b0;
  end

  dbt_down_ctr #(.CW(CW)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_go),
    .load_val(CW'(TRCD - 1)), .done(rcd_done));
  dbt_down_ctr #(.CW(CW)) u_ras (.clk(clk), .rst_n(rst_n), .load(act_go),
    .load_val(CW'(TRAS - 1)), .done(ras_done));
  dbt_down_ctr #(.CW(CW)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act_go),
    .load_val(CW'(TRC - 1)),  .done(rc_done));
  dbt_down_ctr #(.CW(CW)) u_rp  (.clk(clk), .rst_n(rst_n), .load(close_evt),
    .load_val(CW'(TRP - 1)),  .done(rp_done));
  dbt_down_ctr #(.CW(CW)) u_rfc (.clk(clk), .rst_n(rst_n), .load(ref_go),
    .load_val(CW'(TRFC - 1)), .done(rfc_done));
  dbt_down_ctr #(.CW(CW)) u_ap  (.clk(clk), .rst_n(rst_n), .load(ap_req),
    .load_val(ap_load),       .done(ap_done));

  dbt_row_state #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .open_set(act_go), .set_row(req_row),
    .close(close_evt), .req_row(req_row), .row_open(row_open),
    .open_row(open_row), .hit(row_hit));

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_go |=> (row_open && open_row == $past(req_row))); // R2
  AST_COL_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    col_go |-> (row_open && open_row == req_row)); // R3
  AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go |=> !row_open); // R5
  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ap_fire |=> (!row_open && !ap_pend)); // R7
  AST_NO_CMD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ap_pend |-> !(col_go || pre_go)); // R7
  AST_REF_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_go && TRFC > 1) |=> !gnt); // R9
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_cmd > 3'd5 || req_cmd == 3'd0) |-> !gnt); // R11
endmodule

// File: tb/tb_dbt_bank_tracker.sv
`timescale 1ns/1ps
module tb_dbt_bank_tracker;
  localparam int ROW_W = 14;
  localparam int TRCD = 3, TRAS = 8, TRP = 3, TRFC = 12, CL = 3, BL = 8;
  localparam int TRC = TRAS + TRP;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, REF = 3'd5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic [2:0]       req_cmd;
  logic [ROW_W-1:0] req_row;
  logic             req_ap;
  logic gnt_o, open_o, hit_o, gnt_c, open_c, hit_c;
  logic [ROW_W-1:0] orow_o, orow_c;
  bit cp_mode;

  dbt_bank_tracker #(.ROW_W(ROW_W), .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP),
    .TRFC(TRFC), .CL(CL), .BL(BL), .CLOSE_PAGE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_row(req_row),
    .req_ap(req_ap), .gnt(gnt_o), .row_open(open_o), .open_row(orow_o),
    .row_hit(hit_o));

  dbt_bank_tracker #(.ROW_W(ROW_W), .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP),
    .TRFC(TRFC), .CL(CL), .BL(BL), .CLOSE_PAGE(1'b1)) dut_cp (
    .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_row(req_row),
    .req_ap(req_ap), .gnt(gnt_c), .row_open(open_c), .open_row(orow_c),
    .row_hit(hit_c));

  wire             gnt_s  = cp_mode ? gnt_c  : gnt_o;
  wire             open_s = cp_mode ? open_c : open_o;
  wire             hit_s  = cp_mode ? hit_c  : hit_o;
  wire [ROW_W-1:0] orow_s = cp_mode ? orow_c : orow_o;

  int total = 0, bad = 0;
  int now, t_act, t_pre, t_ref, ap_due;
  bit m_open, m_ap;
  logic [ROW_W-1:0] m_row;

  function automatic int burst_len_cycles(input logic [2:0] c);
    return (c == RD) ? CL + BL / 2 : BL / 2;
  endfunction

  function automatic bit model_grant(input logic [2:0] c, input logic [ROW_W-1:0] r);
    case (c)
      ACT:     return !m_open && now >= t_pre + TRP && now >= t_act + TRC
                      && now >= t_ref + TRFC;
      RD, WR:  return m_open && r == m_row && now >= t_act + TRCD && !m_ap;
      PRE:     return m_open && !m_ap && now >= t_act + TRAS;
      REF:     return !m_open && now >= t_pre + TRP && now >= t_ref + TRFC;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      ACT: return "R6"; RD, WR: return "R4"; PRE: return "R5"; REF: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check1(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, now);
    end
  endtask

  task automatic model_reset();
    now = 0; t_act = -1000; t_pre = -1000; t_ref = -1000; ap_due = 0;
    m_open = 0; m_ap = 0; m_row = '0;
  endtask

  task automatic do_reset(input bit cp);
    @(negedge clk);
    cp_mode = cp; rst_n = 1'b0; req_cmd = NOP; req_row = '0; req_ap = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // want < 0: model only; otherwise also compare with the directed value
  task automatic step(input logic [2:0] c, input logic [ROW_W-1:0] r,
                      input bit ap, input int want);
    bit eg;
    @(negedge clk);
    req_cmd = c; req_row = r; req_ap = ap;
    #1;
    eg = model_grant(c, r);
    check1(tag_of(c), "gnt", int'(gnt_s), int'(eg));
    if (want >= 0) check1(tag_of(c), "gnt directed", int'(gnt_s), want);
    check1("R3", "row_hit", int'(hit_s), int'(m_open && r == m_row));
    check1("R2", "row_open", int'(open_s), int'(m_open));
    check1("R10", "open_row", int'(orow_s), m_open ? int'(m_row) : 0);
    if (eg) begin
      case (c)
        ACT: begin m_open = 1; m_row = r; t_act = now; end
        RD, WR: if (ap || cp_mode) begin m_ap = 1; ap_due = now + burst_len_cycles(c); end
        PRE: begin m_open = 0; t_pre = now; end
        REF: t_ref = now;
        default: ;
      endcase
    end
    if (m_ap && now >= ap_due && now >= t_act + TRAS) begin
      m_ap = 0; m_open = 0; t_pre = now;
    end
    now++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(NOP, '0, 1'b0, 0);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      int w;
      logic [2:0] c;
      w = $urandom_range(0, 99);
      if (w < 25) c = ACT; else if (w < 50) c = RD; else if (w < 65) c = WR;
      else if (w < 78) c = PRE; else if (w < 83) c = REF; else if (w < 93) c = NOP;
      else c = 3'($urandom_range(6, 7));
      step(c, ROW_W'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0), -1);
    end
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0147));
    // ---------- open-page directed ----------
    do_reset(1'b0);
    #1;
    check1("R1", "row_open after reset", int'(open_s), 0);
    check1("R1", "open_row after reset", int'(orow_s), 0);
    step(REF, 0, 0, 1);          // c0: R9 idle refresh
    step(ACT, 5, 0, 0);          // c1: R9 blocked by refresh
    idle(9);                     // c2..c10
    step(ACT, 5, 0, 0);          // c11: R9 one cycle early
    step(ACT, 5, 0, 1);          // c12: R2
    step(NOP, 0, 0, 0);          // c13: R11
    step(RD, 5, 0, 0);           // c14: R4 one cycle early
    step(RD, 5, 0, 1);           // c15: R4 window open
    step(3'd6, 5, 0, 0);         // c16: R11 unused code
    step(3'd7, 5, 0, 0);         // c17: R11 unused code
    step(NOP, 0, 0, 0);          // c18
    check1("R10", "row still open", int'(open_s), 1);
    step(PRE, 0, 0, 0);          // c19: R5 one cycle early
    step(PRE, 0, 0, 1);          // c20: R5
    step(RD, 5, 0, 0);           // c21: R3 idle bank
    step(ACT, 7, 0, 0);          // c22: R6 one cycle early
    step(ACT, 7, 0, 1);          // c23: R6
    idle(2);                     // c24, c25
    step(RD, 5, 0, 0);           // c26: R3 row miss
    step(WR, 7, 1, 1);           // c27: R7 write with auto-precharge
    step(RD, 7, 0, 0);           // c28: R7 pending
    idle(2);                     // c29, c30
    step(PRE, 0, 0, 0);          // c31: R7 pending, close fires here
    step(PRE, 0, 0, 0);          // c32: R5 idle bank
    check1("R7", "row closed by auto-precharge", int'(open_s), 0);
    step(ACT, 2, 0, 0);          // c33: R7 TRP after implicit close, early
    step(ACT, 2, 0, 1);          // c34: R7
    step(REF, 0, 0, 0);          // c35: R9 open bank
    random_run(3000);
    // ---------- close-page ----------
    do_reset(1'b1);
    step(ACT, 1, 0, 1);          // c0
    idle(2);                     // c1, c2
    step(RD, 1, 0, 1);           // c3: R8 closes at c10
    idle(6);                     // c4..c9
    step(NOP, 0, 0, 0);          // c10
    check1("R8", "row open at close cycle", int'(open_s), 1);
    step(NOP, 0, 0, 0);          // c11
    check1("R8", "row closed after read", int'(open_s), 0);
    step(ACT, 1, 0, 0);          // c12: R8 early
    step(ACT, 1, 0, 1);          // c13
    random_run(3000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule